// File: doc/BRIEF.md
# SM3 Two-Round and Message-Expansion Unit

This unit runs one of three SM3 hash operations per transaction. Two operations are message-expansion steps that turn four-word groups of earlier schedule words into intermediate and final values for the next four words. The third advances the compression state by two rounds. Each operand is 128 bits wide, made of four 32-bit lanes. Lane i occupies bits [32i+31:32i].

A transaction is accepted when `in_valid` and `in_ready` are both high. The result is then presented on `out_data` with `out_valid` and held until `out_ready` is seen. Only one transaction is in flight at a time.

For the round operation, operand B carries the working words {F,E,B,A} in lanes 0..3. Operand A carries the other four words {H,G,D,C} in a form that has not yet been rotated. The returned lanes {F,E,B,A} can be fed back as the next operand B. Operand C carries the schedule words: lanes 0 and 1 hold W for the two rounds, and lanes 2 and 3 hold W four positions later.

Top module: `sm3u_core`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With `in_op` = 0 (expand step one), let P1(x) = x ^ rotl(x,15) ^ rotl(x,23). Result lane i for i = 0..2 is P1(A[i] ^ C[i] ^ rotl(B[i],15)), and lane 3 is P1(A[3] ^ C[3]).
- R3: With `in_op` = 1 (expand step two), every lane first gets r[i] = A[i] ^ C[i] ^ rotl(B[i],7). Lane 3 is then further XORed with rotl(r[0],6), rotl(r[0],15) and rotl(r[0],30).
- R4: With `in_op[1]` = 1 (two rounds), the round index is masked with 0x3E, so bit 0 of `in_ridx` has no effect. The masked value j names the first round, and the second round is j+1.
- R5: Round operation for j below 16: FF and GG are both three-way XOR, and the constant is 0x79CC4519 rotated left by (j+i) mod 32 for sub-round i. The result lanes 0..3 are F, E, B, A after the two rounds, where the working words start as A=B[3], B=B[2], C=rotl(A[3],9), D=rotl(A[2],9), E=B[1], F=B[0], G=rotl(A[1],19), H=rotl(A[0],19). Each round computes SS1 = rotl(rotl(A,12)+E+Tr,7) and SS2 = SS1^rotl(A,12). It then computes TT1 = FF+D+SS2+(C[i]^C[i+2]) and TT2 = GG+H+SS1+C[i], all additions modulo 2^32. Finally it updates D=C, C=rotl(B,9), B=A, A=TT1, H=G, G=rotl(F,19), F=E, E=TT2^rotl(TT2,9)^rotl(TT2,17).
- R6: Round operation for j of 16 or more: FF is the majority function, GG is (x&y)|(~x&z), and the constant is 0x7A879D8A. The choice follows the masked starting index for both sub-rounds.
- R7: An expansion result is valid in the cycle after acceptance. A round result is valid three cycles after acceptance.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` is low from acceptance until the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, can accept |
| in_op | input | 2 | 0 expand one, 1 expand two, bit 1 set: two rounds |
| in_ridx | input | 6 | First round index (bit 0 ignored) |
| in_a | input | 128 | Operand A |
| in_b | input | 128 | Operand B |
| in_c | input | 128 | Operand C |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_data | output | 128 | Result lanes |

## Verification
The assertions check the handshake on every cycle. They cover the exclusion between `in_ready` and `out_valid`, a held result staying stable, and the latency of one or three cycles for each operation class. The arithmetic cannot be checked that way and is shown only by the bench's scenarios. Those scenarios compare both expansion formulas and the two-round result against independent models. They use random operands, round indices on each side of 16, odd indices that must alias their even neighbour, the 62/63 wrap of the constant rotation, and output stalls.

// File: rtl/sm3u_pkg.sv
package sm3u_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int DATA_W  = WORD_W * LANES;
    localparam int RIDX_W  = 6;
    localparam logic [RIDX_W-1:0] RIDX_MASK = 6'h3E;
    localparam logic [WORD_W-1:0] TCONST_EARLY = 32'h79CC4519;
    localparam logic [WORD_W-1:0] TCONST_LATE  = 32'h7A879D8A;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a; word_t b; word_t c; word_t d;
        word_t e; word_t f; word_t g; word_t h;
    } wstate_t;

    typedef enum logic [1:0] {
        OP_EXP1 = 2'd0,
        OP_EXP2 = 2'd1,
        OP_RND  = 2'd2,
        OP_RNDX = 2'd3
    } op_e;

    function automatic word_t rotl(word_t x, logic [4:0] n);
        return (x << n) | (x >> (6'd32 - {1'b0, n}));
    endfunction

    function automatic word_t perm0(word_t x);
        return x ^ rotl(x, 5'd9) ^ rotl(x, 5'd17);
    endfunction

    function automatic word_t perm1(word_t x);
        return x ^ rotl(x, 5'd15) ^ rotl(x, 5'd23);
    endfunction

    function automatic word_t bool_ff(word_t x, word_t y, word_t z, logic late);
        return late ? ((x & y) | (x & z) | (y & z)) : (x ^ y ^ z);
    endfunction

    function automatic word_t bool_gg(word_t x, word_t y, word_t z, logic late);
        return late ? ((x & y) | (~x & z)) : (x ^ y ^ z);
    endfunction
endpackage

// File: rtl/sm3u_sched.sv
module sm3u_sched
    import sm3u_pkg::*;
(
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    input  logic              sel_step2,
    output logic [DATA_W-1:0] res
);
    word_t s1 [LANES];
    word_t s2 [LANES];
    word_t r0;

    assign r0 = op_a[WORD_W-1:0] ^ op_c[WORD_W-1:0] ^ rotl(op_b[WORD_W-1:0], 5'd7);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        word_t la, lb, lc, mix;
        assign la = op_a[i*WORD_W +: WORD_W];
        assign lb = op_b[i*WORD_W +: WORD_W];
        assign lc = op_c[i*WORD_W +: WORD_W];
        if (i < LANES - 1) begin : g_body
            assign s1[i] = perm1(la ^ lc ^ rotl(lb, 5'd15));
            assign mix   = '0;
        end else begin : g_top
            assign s1[i] = perm1(la ^ lc);
            assign mix   = rotl(r0, 5'd6) ^ rotl(r0, 5'd15) ^ rotl(r0, 5'd30);
        end
        assign s2[i] = la ^ lc ^ rotl(lb, 5'd7) ^ mix;
        assign res[i*WORD_W +: WORD_W] = sel_step2 ? s2[i] : s1[i];
    end
endmodule

// File: rtl/sm3u_step.sv
module sm3u_step
    import sm3u_pkg::*;
(
    input  wstate_t cur,
    input  word_t   w_j,
    input  word_t   wp_j,
    input  word_t   t_j,
    input  logic    late,
    output wstate_t nxt
);
    word_t a12, ss1, ss2, tt1, tt2;

    always_comb begin
        a12 = rotl(cur.a, 5'd12);
        ss1 = rotl(a12 + cur.e + t_j, 5'd7);
        ss2 = ss1 ^ a12;
        tt1 = bool_ff(cur.a, cur.b, cur.c, late) + cur.d + ss2 + wp_j;
        tt2 = bool_gg(cur.e, cur.f, cur.g, late) + cur.h + ss1 + w_j;
        nxt.a = tt1;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 5'd9);
        nxt.d = cur.c;
        nxt.e = perm0(tt2);
        nxt.f = cur.e;
        nxt.g = rotl(cur.f, 5'd19);
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sm3u_core.sv
module sm3u_core
    import sm3u_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [RIDX_W-1:0] in_ridx,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} fsm_e;

    fsm_e              st;
    logic              sub;
    logic              accept;
    wstate_t           ws, ws_load, ws_nxt;
    logic [DATA_W-1:0] cop, res, sched_res;
    logic [RIDX_W-1:0] rnd;
    word_t             w_j, wp_j, t_j;
    logic              late;

    assign in_ready  = (st == S_IDLE);
    assign out_valid = (st == S_HOLD);
    assign out_data  = res;
    assign accept    = in_valid && in_ready;

    sm3u_sched u_sched (
        .op_a(in_a), .op_b(in_b), .op_c(in_c),
        .sel_step2(in_op[0]), .res(sched_res)
    );

    always_comb begin
        ws_load.a = in_b[3*WORD_W +: WORD_W];
        ws_load.b = in_b[2*WORD_W +: WORD_W];
        ws_load.c = rotl(in_a[3*WORD_W +: WORD_W], 5'd9);
        ws_load.d = rotl(in_a[2*WORD_W +: WORD_W], 5'd9);
        ws_load.e = in_b[1*WORD_W +: WORD_W];
        ws_load.f = in_b[0 +: WORD_W];
        ws_load.g = rotl(in_a[1*WORD_W +: WORD_W], 5'd19);
        ws_load.h = rotl(in_a[0 +: WORD_W], 5'd19);
    end

    assign late = (rnd >= 6'd16);
    assign w_j  = sub ? cop[1*WORD_W +: WORD_W] : cop[0 +: WORD_W];
    assign wp_j = w_j ^ (sub ? cop[3*WORD_W +: WORD_W] : cop[2*WORD_W +: WORD_W]);
    assign t_j  = rotl(late ? TCONST_LATE : TCONST_EARLY, rnd[4:0] + {4'd0, sub});

    sm3u_step u_step (
        .cur(ws), .w_j(w_j), .wp_j(wp_j), .t_j(t_j), .late(late), .nxt(ws_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            sub <= 1'b0;
            ws  <= '0;
            cop <= '0;
            rnd <= '0;
            res <= '0;
        end else begin
            case (st)
                S_IDLE: if (accept) begin
                    if (in_op[1]) begin
                        ws  <= ws_load;
                        cop <= in_c;
                        rnd <= in_ridx & RIDX_MASK;
                        sub <= 1'b0;
                        st  <= S_RUN;
                    end else begin
                        res <= sched_res;
                        st  <= S_HOLD;
                    end
                end
                S_RUN: begin
                    ws  <= ws_nxt;
                    sub <= 1'b1;
                    if (sub) begin
                        res <= {ws_nxt.a, ws_nxt.b, ws_nxt.e, ws_nxt.f};
                        st  <= S_HOLD;
                    end
                end
                S_HOLD: if (out_ready) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_ready, out_valid}));
    // R7
    exp_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_op[1]) |=> out_valid);
    // R7
    rnd_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op[1]) |=> (!out_valid ##1 !out_valid ##1 out_valid));
    // R4
    ridx_even_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_RUN) |-> (rnd[0] == 1'b0));
endmodule

// File: tb/sm3u_core_test.sv
module sm3u_core_test;
    logic clk = 0, rst = 1;
    logic in_valid = 0, out_ready = 0;
    logic [1:0] in_op = 0;
    logic [5:0] in_ridx = 0;
    logic [127:0] in_a = 0, in_b = 0, in_c = 0;
    logic in_ready, out_valid;
    logic [127:0] out_data;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sm3u_core uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_ridx(in_ridx), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        int k = n % 32;
        return (k == 0) ? x : ((x << k) | (x >> (32 - k)));
    endfunction
    function automatic logic [31:0] ln(logic [127:0] v, int i);
        return v[32*i +: 32];
    endfunction
    function automatic logic [31:0] mp1(logic [31:0] x);
        return x ^ rl(x, 15) ^ rl(x, 23);
    endfunction

    function automatic logic [127:0] m_exp1(logic [127:0] a, b, c);
        logic [127:0] r;
        for (int i = 0; i < 3; i++)
            r[32*i +: 32] = mp1(ln(a,i) ^ ln(c,i) ^ rl(ln(b,i), 15));
        r[127:96] = mp1(ln(a,3) ^ ln(c,3));
        return r;
    endfunction

    function automatic logic [127:0] m_exp2(logic [127:0] a, b, c);
        logic [127:0] r;
        for (int i = 0; i < 4; i++)
            r[32*i +: 32] = rl(ln(b,i), 7) ^ ln(c,i) ^ ln(a,i);
        r[127:96] = r[127:96] ^ rl(r[31:0], 6) ^ rl(r[31:0], 15) ^ rl(r[31:0], 30);
        return r;
    endfunction

    function automatic logic [127:0] m_rnd(logic [127:0] a, b, c, logic [5:0] idx);
        logic [31:0] v [8];
        logic [31:0] k, s1, s2, f, g, t1, t2;
        int j = int'(idx) & 62;
        k = (j < 16) ? 32'h79CC4519 : 32'h7A879D8A;
        v[0] = ln(b,3); v[1] = ln(b,2); v[2] = rl(ln(a,3), 9); v[3] = rl(ln(a,2), 9);
        v[4] = ln(b,1); v[5] = ln(b,0); v[6] = rl(ln(a,1), 19); v[7] = rl(ln(a,0), 19);
        for (int i = 0; i < 2; i++) begin
            s1 = rl(rl(v[0], 12) + v[4] + rl(k, j + i), 7);
            s2 = s1 ^ rl(v[0], 12);
            f = (j < 16) ? (v[0] ^ v[1] ^ v[2]) : ((v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]));
            g = (j < 16) ? (v[4] ^ v[5] ^ v[6]) : ((v[4] & v[5]) | (~v[4] & v[6]));
            t1 = f + v[3] + s2 + (ln(c,i) ^ ln(c,i+2));
            t2 = g + v[7] + s1 + ln(c,i);
            v[3] = v[2]; v[2] = rl(v[1], 9); v[1] = v[0]; v[0] = t1;
            v[7] = v[6]; v[6] = rl(v[5], 19); v[5] = v[4];
            v[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
        end
        return {v[0], v[1], v[4], v[5]};
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] op, logic [5:0] idx, logic [127:0] a, b, c,
                          int stall, string req);
        logic [127:0] exp;
        logic [127:0] held;
        int lat = 1;
        int want;
        exp  = op[1] ? m_rnd(a, b, c, idx) : (op[0] ? m_exp2(a, b, c) : m_exp1(a, b, c));
        want = op[1] ? 3 : 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_op = op; in_ridx = idx; in_a = a; in_b = b; in_c = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == want, "R7 latency", 128'(lat), 128'(want));
        chk(out_data == exp, req, out_data, exp);
        held = out_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(out_valid && out_data == held && !in_ready, "R8 hold", out_data, held);
        end
        out_ready = 1;
        @(negedge clk);
        out_ready = 0;
        chk(!out_valid && in_ready, "R8 release", 128'(out_valid), 128'(0));
    endtask

    function automatic logic [127:0] r128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(in_ready && !out_valid, "R1 reset", {in_ready, out_valid}, 2'b10);

        // directed: R2 all-zero, R3 cross-lane, R4 odd index, R5/R6 boundary
        run_op(2'd0, 0, '0, '0, '0, 0, "R2 zero");
        run_op(2'd0, 0, {4{32'h8000_0001}}, {4{32'hFFFF_FFFF}}, '0, 1, "R2 exp1");
        run_op(2'd1, 0, {96'd0, 32'h1}, '0, '0, 2, "R3 exp2 lane0 feed");
        run_op(2'd2, 6'd15, r128(), r128(), r128(), 0, "R4 odd 15 as 14 R5");
        run_op(2'd2, 6'd14, 128'h1, 128'h2, 128'h3, 0, "R5 j14");
        run_op(2'd2, 6'd16, 128'h1, 128'h2, 128'h3, 0, "R6 j16");
        run_op(2'd2, 6'd63, r128(), r128(), r128(), 2, "R4 R6 j62 wrap");
        run_op(2'd3, 6'd31, r128(), r128(), r128(), 0, "R4 R6 op3 j30");

        for (int t = 0; t < 300; t++) begin
            logic [1:0] op = 2'($urandom_range(0, 3));
            logic [5:0] idx = 6'($urandom);
            run_op(op, idx, r128(), r128(), r128(), int'($urandom_range(0, 2)),
                   op[1] ? ((idx & 6'h3E) < 16 ? "R5 random" : "R6 random")
                         : (op[0] ? "R3 random" : "R2 random"));
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule